// File: doc/BRIEF.md
# Dual-Stack 16-bit Stack Processor Core

This core executes programs made of 16-bit instructions that correspond directly to Forth primitives. Code and data share one memory, reached through a single port with a combinational read path. The core keeps a data stack whose top (T) is held in a register and whose second entry is N. It also keeps a return stack whose top is R, and a 13-bit word program counter. It has no flags and no other architectural registers.

Every instruction takes two clock cycles. In the first, the port fetches the word at byte address 2*PC. In the second, the instruction executes, and an ALU instruction may use the port for one data load or store at byte address T. Addresses whose two top bits are `01` (byte 16384 to 32767) form the memory-mapped I/O window. A data access to that window raises a strobe so that surrounding logic can steer it.

Top module: `stack_cpu16`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the core drives `mem_addr` = 0 with `mem_we` low, so the first fetch comes from byte address 0 and PC restarts at 0.
- R2: Fetch and execute cycles alternate. A fetch drives `mem_addr` = 2*PC and never writes. A jump to word target A therefore makes the next fetch use byte address 2*A.
- R3: An instruction with bit 15 set is a literal. It pushes bits 14..0, zero-extended, as the new T, and the old T becomes N.
- R4: Bits 15..13 = `000` is a jump. PC is loaded with the absolute target in bits 12..0.
- R5: Bits 15..13 = `001` is a conditional jump. It always pops T (N becomes T). PC takes the bits 12..0 target only when the popped T was zero; otherwise PC advances by one.
- R6: Bits 15..13 = `010` is a call. It pushes the byte address of the next instruction, (PC+1)*2, onto the return stack and loads PC with the bits 12..0 target.
- R7: Bits 15..13 = `011` is an ALU instruction, and bits 11..8 choose the new T. The codes are: 0 T, 1 N, 2 T+N, 3 N and T, 4 N or T, 5 N xor T, 6 not T, 7 equal, 8 N<T signed, 9 N shifted right by T[3:0], 10 T-1, 11 R, 12 memory at T, 13 N shifted left by T[3:0], 14 data stack pointer, 15 N<T unsigned. Comparisons give 16'hFFFF when true and 0 when false.
- R8: ALU bit 12 set loads PC with R shifted right by one bit (R[13:1]).
- R9: ALU bits 1..0 and 3..2 are 2-bit two's-complement adjustments (+1, 0, -1) of the data and return stack pointers. Bit 7 writes the old T into the new N slot. Bit 6 writes the old T into the new R slot.
- R10: ALU bit 5 stores N at byte address T during the execute cycle (`mem_addr` = T, `mem_wdata` = N, `mem_we` = 1). No other instruction writes memory.
- R11: ALU code 12 loads the new T from `mem_rdata` while `mem_addr` = T in the execute cycle.
- R12: `io_strobe` is high exactly in execute cycles that load (code 12) or store (bit 5) at an address whose bits 15..14 are `01`.
- R13: The data stack holds 33 values (T plus 32 stored entries), and the return stack holds 32 values. A full fill followed by a full drain returns every value, and both stack pointers wrap modulo 32 without any error signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Combinational read data for `mem_addr` |
| mem_addr | output | 16 | Byte address: 2*PC when fetching, T for data accesses |
| mem_wdata | output | 16 | Store data (N) |
| mem_we | output | 1 | Store strobe |
| io_strobe | output | 1 | Data access falls in the I/O window |

## Verification
After reset is released, the fetch of the instruction at position k is visible on `mem_addr` 2k cycles later. Its store, if any, is visible one cycle after that fetch. The bench therefore waits for the jump target's fetch exactly two edges after release. It does not sample stack contents directly. Every result is brought out through a store to a known address, and each program ends in a self-jump, so the logged write list is final once the run has covered twice the program length in cycles. All outputs are sampled at the falling edge, half a period away from the register updates.

// File: rtl/stack_cpu16_pkg.sv
package stack_cpu16_pkg;

    localparam int WORD_W = 16;
    localparam int PC_W   = 13;

    typedef enum logic [1:0] {
        CLS_JUMP  = 2'b00,
        CLS_CJUMP = 2'b01,
        CLS_CALL  = 2'b10,
        CLS_ALU   = 2'b11
    } cls_e;

    typedef enum logic [3:0] {
        OP_T    = 4'd0,
        OP_N    = 4'd1,
        OP_ADD  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_INV  = 4'd6,
        OP_EQ   = 4'd7,
        OP_SLT  = 4'd8,
        OP_SHR  = 4'd9,
        OP_DEC  = 4'd10,
        OP_R    = 4'd11,
        OP_LOAD = 4'd12,
        OP_SHL  = 4'd13,
        OP_DEPTH= 4'd14,
        OP_ULT  = 4'd15
    } alu_op_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [PC_W-1:0]    pc;
        logic [WORD_W-1:0]  ir;
        logic [WORD_W-1:0]  t;
    } core_state_t;

endpackage

// File: rtl/stack_cpu16_lifo.sv
module stack_cpu16_lifo #(
    parameter int W  = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    delta_i,
    input  logic          we_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  top_o,
    output logic [AW-1:0] ptr_o
);
    localparam int ENTRIES = 1 << AW;

    logic [AW-1:0] sp_d, sp_q;
    logic [W-1:0]  slot_q [ENTRIES];

    always_comb begin
        sp_d = sp_q + {{(AW-2){delta_i[1]}}, delta_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slot_q[i] <= '0;
            end
        end else if (we_i) begin
            slot_q[sp_d] <= wdata_i;
        end
    end

    assign top_o = slot_q[sp_q];
    assign ptr_o = sp_q;

    // R9: a zero adjustment leaves the pointer where it was
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (delta_i == 2'b00) |=> (sp_q == $past(sp_q)));

    // R9: a written value is the top entry on the following cycle
    a_r9_write_readback: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (top_o == $past(wdata_i)));

endmodule

// File: rtl/stack_cpu16_alu.sv
module stack_cpu16_alu
    import stack_cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e       op_i,
    input  logic [W-1:0]  t_i,
    input  logic [W-1:0]  n_i,
    input  logic [W-1:0]  r_i,
    input  logic [W-1:0]  rdata_i,
    input  logic [W-1:0]  depth_i,
    output logic [W-1:0]  res_o
);
    localparam logic [W-1:0] TRUE_V  = '1;
    localparam logic [W-1:0] FALSE_V = '0;

    logic [3:0] shamt;
    assign shamt = t_i[3:0];

    always_comb begin
        unique case (op_i)
            OP_T:     res_o = t_i;
            OP_N:     res_o = n_i;
            OP_ADD:   res_o = t_i + n_i;
            OP_AND:   res_o = n_i & t_i;
            OP_OR:    res_o = n_i | t_i;
            OP_XOR:   res_o = n_i ^ t_i;
            OP_INV:   res_o = ~t_i;
            OP_EQ:    res_o = (n_i == t_i) ? TRUE_V : FALSE_V;
            OP_SLT:   res_o = ($signed(n_i) < $signed(t_i)) ? TRUE_V : FALSE_V;
            OP_SHR:   res_o = n_i >> shamt;
            OP_DEC:   res_o = t_i - 1'b1;
            OP_R:     res_o = r_i;
            OP_LOAD:  res_o = rdata_i;
            OP_SHL:   res_o = n_i << shamt;
            OP_DEPTH: res_o = depth_i;
            OP_ULT:   res_o = (n_i < t_i) ? TRUE_V : FALSE_V;
            default:  res_o = t_i;
        endcase
    end

endmodule

// File: rtl/stack_cpu16.sv
module stack_cpu16
    import stack_cpu16_pkg::*;
#(
    parameter int DS_AW = 5,
    parameter int RS_AW = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] mem_rdata,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    output logic        io_strobe
);
    localparam logic [1:0] IO_TAG = 2'b01;
    localparam logic [1:0] ADJ_UP = 2'b01;
    localparam logic [1:0] ADJ_DN = 2'b11;

    core_state_t st_d, st_q;

    logic [WORD_W-1:0] n_top, r_top, alu_res, depth_w;
    logic [DS_AW-1:0]  d_ptr;
    logic [RS_AW-1:0]  r_ptr;
    logic [1:0]        d_adj, r_adj;
    logic              d_we, r_we;
    logic [WORD_W-1:0] d_wdata, r_wdata;
    logic [PC_W-1:0]   pc_inc;

    logic              is_lit;
    cls_e              cls;
    logic [PC_W-1:0]   target;
    alu_op_e           op;
    logic              f_ret, f_tn, f_tr, f_wr;
    logic              exec_alu, data_access;

    assign is_lit  = st_q.ir[15];
    assign cls     = cls_e'(st_q.ir[14:13]);
    assign target  = st_q.ir[PC_W-1:0];
    assign op      = alu_op_e'(st_q.ir[11:8]);
    assign f_ret   = st_q.ir[12];
    assign f_tn    = st_q.ir[7];
    assign f_tr    = st_q.ir[6];
    assign f_wr    = st_q.ir[5];
    assign pc_inc  = st_q.pc + 1'b1;
    assign depth_w = WORD_W'(d_ptr);

    assign exec_alu    = (st_q.phase == PH_EXEC) && !is_lit && (cls == CLS_ALU);
    assign data_access = exec_alu && (f_wr || (op == OP_LOAD));

    stack_cpu16_lifo #(.W(WORD_W), .AW(DS_AW)) i_dstack (
        .clk     (clk),
        .rst     (rst),
        .delta_i (d_adj),
        .we_i    (d_we),
        .wdata_i (d_wdata),
        .top_o   (n_top),
        .ptr_o   (d_ptr)
    );

    stack_cpu16_lifo #(.W(WORD_W), .AW(RS_AW)) i_rstack (
        .clk     (clk),
        .rst     (rst),
        .delta_i (r_adj),
        .we_i    (r_we),
        .wdata_i (r_wdata),
        .top_o   (r_top),
        .ptr_o   (r_ptr)
    );

    stack_cpu16_alu #(.W(WORD_W)) i_alu (
        .op_i    (op),
        .t_i     (st_q.t),
        .n_i     (n_top),
        .r_i     (r_top),
        .rdata_i (mem_rdata),
        .depth_i (depth_w),
        .res_o   (alu_res)
    );

    always_comb begin
        st_d      = st_q;
        d_adj     = 2'b00;
        r_adj     = 2'b00;
        d_we      = 1'b0;
        r_we      = 1'b0;
        d_wdata   = st_q.t;
        r_wdata   = st_q.t;
        mem_addr  = {2'b00, st_q.pc, 1'b0};
        mem_wdata = n_top;
        mem_we    = 1'b0;
        io_strobe = 1'b0;

        if (st_q.phase == PH_FETCH) begin
            st_d.ir    = mem_rdata;
            st_d.phase = PH_EXEC;
        end else begin
            st_d.phase = PH_FETCH;
            st_d.pc    = pc_inc;
            mem_addr   = st_q.t;
            if (is_lit) begin
                st_d.t = {1'b0, st_q.ir[14:0]};
                d_adj  = ADJ_UP;
                d_we   = 1'b1;
            end else begin
                unique case (cls)
                    CLS_JUMP: begin
                        st_d.pc = target;
                    end
                    CLS_CJUMP: begin
                        st_d.t = n_top;
                        d_adj  = ADJ_DN;
                        if (st_q.t == '0) begin
                            st_d.pc = target;
                        end
                    end
                    CLS_CALL: begin
                        r_adj   = ADJ_UP;
                        r_we    = 1'b1;
                        r_wdata = {2'b00, pc_inc, 1'b0};
                        st_d.pc = target;
                    end
                    CLS_ALU: begin
                        st_d.t = alu_res;
                        d_adj  = st_q.ir[1:0];
                        r_adj  = st_q.ir[3:2];
                        d_we   = f_tn;
                        r_we   = f_tr;
                        mem_we = f_wr;
                        if (f_ret) begin
                            st_d.pc = r_top[PC_W:1];
                        end
                    end
                    default: ;
                endcase
            end
            io_strobe = data_access && (st_q.t[15:14] == IO_TAG);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_FETCH, pc: '0, ir: '0, t: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: fetch and execute strictly alternate
    a_r2_phase_toggles: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.phase != $past(st_q.phase)));

    // R10: nothing is written while an instruction word is fetched
    a_r10_no_write_in_fetch: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_FETCH) |-> !mem_we);

    // R12: the I/O strobe only accompanies an execute cycle
    a_r12_io_exec_only: assert property (@(posedge clk) disable iff (rst)
        io_strobe |-> (st_q.phase == PH_EXEC));

    // R3: a literal lands in T zero-extended
    a_r3_literal_value: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_EXEC && is_lit) |=> (st_q.t == {1'b0, $past(st_q.ir[14:0])}));

    // R5: a zero T makes the conditional jump take its target
    a_r5_cjump_taken: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_EXEC && !is_lit && cls == CLS_CJUMP && st_q.t == '0)
        |=> (st_q.pc == $past(target)));

    // R6: a call leaves the return byte address on top of the return stack
    a_r6_call_push: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_EXEC && !is_lit && cls == CLS_CALL)
        |=> (r_top == $past({2'b00, pc_inc, 1'b0})));

endmodule

// File: tb/test_stack_cpu16.sv
module test_stack_cpu16;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] RES_ADDR = 16'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_we, io_strobe;

    logic [15:0] mem [256];
    int n_checks = 0;
    int n_fail = 0;
    int wr_count, io_count;
    logic [15:0] log_addr [4];
    logic [15:0] log_data [4];
    int wp;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[8:1]];

    stack_cpu16 i_stack_cpu16 (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .io_strobe (io_strobe)
    );

    always @(posedge clk) begin
        if (rst) begin
            wr_count <= 0;
            io_count <= 0;
        end else begin
            if (mem_we) begin
                if (wr_count < 4) begin
                    log_addr[wr_count] <= mem_addr;
                    log_data[wr_count] <= mem_wdata;
                end
                wr_count <= wr_count + 1;
            end
            if (io_strobe) io_count <= io_count + 1;
        end
    end

    function automatic logic [15:0] i_lit(input logic [14:0] v);
        return {1'b1, v};
    endfunction
    function automatic logic [15:0] i_br(input logic [1:0] c, input int a);
        return {1'b0, c, 13'(a)};
    endfunction
    function automatic logic [15:0] i_alu(input int op, input bit ret, input bit tn,
                                          input bit tr, input bit wr,
                                          input logic [1:0] ra, input logic [1:0] da);
        return {3'b011, ret, 4'(op), tn, tr, wr, 1'b0, ra, da};
    endfunction

    task automatic put(input logic [15:0] w);
        mem[wp] = w;
        wp++;
    endtask
    task automatic put_val(input logic [15:0] v);
        if (v[15]) begin
            put(i_lit(~v[14:0]));
            put(i_alu(6, 0, 0, 0, 0, 2'b00, 2'b00));
        end else begin
            put(i_lit(v[14:0]));
        end
    endtask
    task automatic put_store(input logic [15:0] a);
        put(i_lit(a[14:0]));
        put(i_alu(1, 0, 0, 0, 1, 2'b00, 2'b11));
    endtask
    task automatic put_halt();
        put(i_br(2'b00, wp));
    endtask
    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
        wp = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic run_prog();
        start();
        for (int i = 0; i < 2 * wp + 8; i++) step();
    endtask

    task automatic check_one_write(input string req, input logic [15:0] a,
                                   input logic [15:0] d);
        check(wr_count == 1, req, 16'(wr_count), 16'd1);
        check(log_addr[0] == a && log_data[0] == d, req, log_data[0], d);
    endtask

    function automatic logic [15:0] model(input int op, input logic [15:0] n,
                                          input logic [15:0] t, input logic [15:0] rd);
        case (op)
            0: return t;
            1: return n;
            2: return t + n;
            3: return n & t;
            4: return n | t;
            5: return n ^ t;
            6: return ~t;
            7: return (n == t) ? 16'hFFFF : 16'h0;
            8: return ($signed(n) < $signed(t)) ? 16'hFFFF : 16'h0;
            9: return n >> t[3:0];
            10: return t - 16'd1;
            11: return 16'h0;
            12: return rd;
            13: return n << t[3:0];
            14: return 16'd2;
            default: return (n < t) ? 16'hFFFF : 16'h0;
        endcase
    endfunction

    function automatic bit binary_op(input int op);
        return op inside {1, 2, 3, 4, 5, 7, 8, 9, 13, 15};
    endfunction

    initial begin
        logic [15:0] va [6];
        logic [15:0] vb [6];
        logic [15:0] expv, rdv;
        int s;
        va = '{16'h0003, 16'hFFFE, 16'h1234, 16'h8000, 16'h00F0, 16'h0007};
        vb = '{16'h0005, 16'h0002, 16'h1234, 16'h7FFF, 16'h4006, 16'h0001};

        // R1: reset state
        clear_mem();
        put_halt();
        rst = 1'b1;
        step();
        check(mem_addr == 16'h0 && !mem_we, "R1 in reset", mem_addr, 16'h0);
        step();
        rst = 1'b0;
        check(mem_addr == 16'h0 && !mem_we, "R1 first fetch", mem_addr, 16'h0);

        // R2 R4: jump and fetch address
        clear_mem();
        put(i_br(2'b00, 5));
        put_store(16'h0102);
        wp = 5;
        put(i_lit(15'h004D));
        put_store(RES_ADDR);
        put_halt();
        start();
        step();
        step();
        check(mem_addr == 16'd10, "R2 fetch at target", mem_addr, 16'd10);
        for (int i = 0; i < 30; i++) step();
        check_one_write("R4 jump", RES_ADDR, 16'h004D);

        // R5: conditional jump, taken and not taken, always popping
        for (int c = 0; c < 2; c++) begin
            clear_mem();
            put(i_lit(15'd55));
            put(i_lit(c == 0 ? 15'd0 : 15'd3));
            put(i_br(2'b01, 10));
            put_store(RES_ADDR);
            put_halt();
            wp = 10;
            put_store(16'h0102);
            put_halt();
            run_prog();
            check_one_write(c == 0 ? "R5 taken" : "R5 not taken",
                            c == 0 ? 16'h0102 : RES_ADDR, 16'd55);
        end

        // R6 R8 R9: call, read R, return
        clear_mem();
        put(i_br(2'b10, 8));
        put_store(RES_ADDR);
        put_halt();
        wp = 8;
        put(i_alu(11, 0, 1, 0, 0, 2'b00, 2'b01));
        put_store(16'h0104);
        put(i_alu(0, 1, 0, 0, 0, 2'b11, 2'b00));
        run_prog();
        check(wr_count == 2, "R6 write count", 16'(wr_count), 16'd2);
        check(log_addr[0] == 16'h0104 && log_data[0] == 16'd2, "R6 return address",
              log_data[0], 16'd2);
        check(log_addr[1] == RES_ADDR && log_data[1] == 16'd2, "R8 return taken",
              log_addr[1], RES_ADDR);

        // R9: T copied to return stack
        clear_mem();
        put(i_lit(15'h1234));
        put(i_alu(0, 0, 0, 1, 0, 2'b01, 2'b00));
        put(i_lit(15'd99));
        put(i_alu(11, 0, 0, 0, 0, 2'b00, 2'b00));
        put_store(RES_ADDR);
        put_halt();
        run_prog();
        check_one_write("R9 T to R copy", RES_ADDR, 16'h1234);

        // R13: 33 data stack values survive
        clear_mem();
        s = 0;
        for (int j = 1; j <= 33; j++) begin
            put(i_lit(15'(j * 7 + 3)));
            s += j * 7 + 3;
        end
        for (int j = 0; j < 32; j++) put(i_alu(2, 0, 0, 0, 0, 2'b00, 2'b11));
        put_store(RES_ADDR);
        put_halt();
        run_prog();
        check_one_write("R13 data stack depth", RES_ADDR, 16'(s));

        // R13: 32 return stack values survive
        clear_mem();
        s = 0;
        for (int j = 1; j <= 32; j++) begin
            put(i_lit(15'(j * 7 + 3)));
            put(i_alu(1, 0, 0, 1, 0, 2'b01, 2'b11));
            s += j * 7 + 3;
        end
        for (int j = 0; j < 32; j++) put(i_alu(11, 0, 1, 0, 0, 2'b11, 2'b01));
        for (int j = 0; j < 32; j++) put(i_alu(2, 0, 0, 0, 0, 2'b00, 2'b11));
        put_store(RES_ADDR);
        put_halt();
        run_prog();
        check_one_write("R13 return stack depth", RES_ADDR, 16'(s));

        // R3 R7 R10 R11 R12: sweep every ALU code over operand pairs
        for (int op = 0; op < 16; op++) begin
            for (int p = 0; p < 6; p++) begin
                clear_mem();
                put_val(va[p]);
                put_val(vb[p]);
                put(i_alu(op, 0, 0, 0, 0, 2'b00, binary_op(op) ? 2'b11 : 2'b00));
                put_store(RES_ADDR);
                put_halt();
                rdv = mem[vb[p][8:1]];
                expv = model(op, va[p], vb[p], rdv);
                run_prog();
                check(wr_count == 1 && log_addr[0] == RES_ADDR && log_data[0] == expv,
                      $sformatf("R7 op %0d pair %0d", op, p), log_data[0], expv);
                check(io_count == ((op == 12 && vb[p][15:14] == 2'b01) ? 1 : 0),
                      $sformatf("R12 io op %0d pair %0d", op, p), 16'(io_count),
                      (op == 12 && vb[p][15:14] == 2'b01) ? 16'd1 : 16'd0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule